// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with Word Operations

This block is the combinational arithmetic core of a 64-bit integer pipeline. Each cycle the issue stage presents two operands, a 4-bit operation code, a word-mode flag and the current program counter. The block returns the operation result, a set of comparison flags for branch resolution, the link address for jump-and-link, and the target address for a register-indirect jump. Decode, register file, memory access, branch selection and multiply/divide are handled by neighbouring blocks.

Addition and subtraction share one adder, with subtraction done by inverting the second operand and injecting a carry of one. Shifts go through one right-shifting network that also serves left shifts by reversing the bits before and after it. When word mode is set, addition, subtraction and shifts work on the low 32 bits, and their result is sign-extended from bit 31 to all 64 bits.

Top module: `rvx_int_exec`

## Requirements
- R1: With word_mode low, op code 0 gives opnd_a + opnd_b and op code 1 gives opnd_a - opnd_b, both modulo 2^64.
- R2: With word_mode high, op codes 0 and 1 form the 32-bit sum or difference of the low halves and sign-extend its bit 31 through bits 63..32.
- R3: Op code 3 returns 1 when opnd_a is less than opnd_b read as two's complement numbers, else 0; op code 4 does the same with both read as unsigned. word_mode has no effect on either.
- R4: Op codes 5, 8 and 9 give the bitwise XOR, OR and AND of the full operands; word_mode has no effect on them.
- R5: With word_mode low, op codes 2 (left), 6 (logical right, zero fill) and 7 (arithmetic right, copies of bit 63) shift opnd_a by the amount in opnd_b bits 5..0; higher bits of opnd_b are ignored.
- R6: With word_mode high, op codes 2, 6 and 7 shift the low 32 bits of opnd_a by opnd_b bits 4..0 (logical right treats them as unsigned, arithmetic right copies bit 31) and sign-extend the 32-bit result from bit 31.
- R7: Op code 10 returns opnd_b unchanged; op code 11 returns pc_in + opnd_b modulo 2^64; word_mode has no effect on either.
- R8: Op codes 12 through 15 return zero.
- R9: link_addr equals pc_in + 4, or pc_in + 2 when short_insn is high, modulo 2^64, for any op code.
- R10: jump_target equals opnd_a + opnd_b modulo 2^64 with bit 0 cleared, for any op code.
- R11: cmp_eq, cmp_lt and cmp_ltu report equality, signed less-than and unsigned less-than of the full 64-bit operands for any op code and word_mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 shift left, 3 signed less-than, 4 unsigned less-than, 5 xor, 6 logical right, 7 arithmetic right, 8 or, 9 and, 10 pass second operand, 11 pc plus second operand) |
| word_mode | input | 1 | Selects 32-bit arithmetic and shifts with sign-extended result |
| opnd_a | input | 64 | First source operand |
| opnd_b | input | 64 | Second source operand (register value or extended immediate) |
| pc_in | input | 64 | Address of the current instruction |
| short_insn | input | 1 | Current instruction is 2 bytes long instead of 4 |
| result | output | 64 | Operation result |
| link_addr | output | 64 | Address of the following instruction |
| jump_target | output | 64 | Register-indirect jump target, bit 0 cleared |
| cmp_eq | output | 1 | Operands are equal |
| cmp_lt | output | 1 | opnd_a below opnd_b, signed |
| cmp_ltu | output | 1 | opnd_a below opnd_b, unsigned |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle the stimulus is applied, with no register between input and output. The bench changes the inputs, waits half a clock period so all combinational paths have settled, and compares every output against a value computed arithmetically from the requirements before the next change. Sweeps cover all sixteen op codes in both modes across a grid of sign-boundary operands, and every shift amount from 0 to 63 in both modes.

// File: rtl/rvx_alu_pkg.sv
package rvx_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_SLL    = 4'd2,
      OP_SLT    = 4'd3,
      OP_SLTU   = 4'd4,
      OP_XOR    = 4'd5,
      OP_SRL    = 4'd6,
      OP_SRA    = 4'd7,
      OP_OR     = 4'd8,
      OP_AND    = 4'd9,
      OP_PASS_B = 4'd10,
      OP_PC_ADD = 4'd11
   } alu_op_e;

   localparam int unsigned OP_FIRST_UNUSED = 12;

endpackage

// File: rtl/rvx_addsub.sv
// Shared adder: subtraction by inverted operand and carry-in of one.
module rvx_addsub #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum
);
   logic [W-1:0] b_eff;

   assign b_eff = sub ? ~b : b;
   assign sum   = a + b_eff + W'(sub);
endmodule

// File: rtl/rvx_cmp.sv
// Equality and ordering flags; signed order derived from the unsigned borrow.
module rvx_cmp #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         eq,
   output logic         lt,
   output logic         ltu
);
   logic [W:0] diff;

   assign diff = {1'b0, a} - {1'b0, b};
   assign eq   = (a == b);
   assign ltu  = diff[W];
   assign lt   = (a[W-1] ^ b[W-1]) ? a[W-1] : diff[W];
endmodule

// File: rtl/rvx_shift.sv
// Single right-shift network; left shifts reuse it through bit reversal.
module rvx_shift #(
   parameter int unsigned W      = 64,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned SW    = $clog2(W)
) (
   input  logic [W-1:0]  val,
   input  logic [SW-1:0] amt,
   input  logic          right,
   input  logic          arith,
   output logic [W-1:0]  res
);
   function automatic logic [W-1:0] bit_rev(input logic [W-1:0] x);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = x[W-1-i];
      return r;
   endfunction

   generate
      if (STAGED) begin : g_staged
         logic [W-1:0] stg [0:SW];
         logic         fill;

         assign stg[0] = right ? val : bit_rev(val);
         assign fill   = right & arith & val[W-1];

         for (genvar s = 0; s < SW; s++) begin : g_stage
            localparam int unsigned D = 1 << s;
            assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
         end

         assign res = right ? stg[SW] : bit_rev(stg[SW]);
      end else begin : g_behav
         always_comb begin
            if (!right)     res = val << amt;
            else if (arith) res = W'($signed(val) >>> amt);
            else            res = val >> amt;
         end
      end
   endgenerate
endmodule

// File: rtl/rvx_int_exec.sv
module rvx_int_exec
   import rvx_alu_pkg::*;
#(
   parameter int unsigned XLEN         = 64,
   parameter int unsigned WLEN         = 32,
   parameter int unsigned FULL_ILEN    = 4,
   parameter int unsigned SHORT_ILEN   = 2,
   parameter bit          STAGED_SHIFT = 1'b1
) (
   input  logic [3:0]      op_sel,
   input  logic            word_mode,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic [XLEN-1:0] pc_in,
   input  logic            short_insn,
   output logic [XLEN-1:0] result,
   output logic [XLEN-1:0] link_addr,
   output logic [XLEN-1:0] jump_target,
   output logic            cmp_eq,
   output logic            cmp_lt,
   output logic            cmp_ltu
);
   localparam int unsigned XSH = $clog2(XLEN);
   localparam int unsigned WSH = $clog2(WLEN);
   localparam int unsigned EXT = XLEN - WLEN;

   generate
      if (WLEN >= XLEN) begin : g_bad_wlen
         $error("WLEN must be narrower than XLEN");
      end
      if ((1 << XSH) != XLEN || (1 << WSH) != WLEN) begin : g_bad_pow2
         $error("XLEN and WLEN must be powers of two");
      end
      if (SHORT_ILEN == 0 || FULL_ILEN <= SHORT_ILEN) begin : g_bad_ilen
         $error("instruction lengths must satisfy 0 < SHORT_ILEN < FULL_ILEN");
      end
   endgenerate

   function automatic logic [XLEN-1:0] sext_w(input logic [WLEN-1:0] x);
      return {{EXT{x[WLEN-1]}}, x};
   endfunction

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic is_addsub, is_shift, word_eff;
   assign is_addsub = (op == OP_ADD) || (op == OP_SUB);
   assign is_shift  = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
   assign word_eff  = word_mode && (is_addsub || is_shift);

   // ---------------- shared adder ----------------
   logic [XLEN-1:0] add_a, add_sum, add_res;
   assign add_a = (op == OP_PC_ADD) ? pc_in : opnd_a;

   rvx_addsub #(.W(XLEN)) u_main_add (
      .a   (add_a),
      .b   (opnd_b),
      .sub (op == OP_SUB),
      .sum (add_sum)
   );

   assign add_res = word_eff ? sext_w(add_sum[WLEN-1:0]) : add_sum;

   // ---------------- shifter ----------------
   logic [XLEN-1:0] sh_in, sh_out, sh_res;
   logic [XSH-1:0]  sh_amt;

   always_comb begin
      if (!word_eff)          sh_in = opnd_a;
      else if (op == OP_SRA)  sh_in = sext_w(opnd_a[WLEN-1:0]);
      else                    sh_in = {{EXT{1'b0}}, opnd_a[WLEN-1:0]};
   end

   assign sh_amt = word_eff ? {{(XSH-WSH){1'b0}}, opnd_b[WSH-1:0]} : opnd_b[XSH-1:0];

   rvx_shift #(.W(XLEN), .STAGED(STAGED_SHIFT)) u_shift (
      .val   (sh_in),
      .amt   (sh_amt),
      .right (op != OP_SLL),
      .arith (op == OP_SRA),
      .res   (sh_out)
   );

   assign sh_res = word_eff ? sext_w(sh_out[WLEN-1:0]) : sh_out;

   // ---------------- comparator (also drives set-less-than) ----------------
   rvx_cmp #(.W(XLEN)) u_cmp (
      .a   (opnd_a),
      .b   (opnd_b),
      .eq  (cmp_eq),
      .lt  (cmp_lt),
      .ltu (cmp_ltu)
   );

   // ---------------- program-counter helpers ----------------
   logic [XLEN-1:0] tgt_sum;

   rvx_addsub #(.W(XLEN)) u_tgt_add (
      .a   (opnd_a),
      .b   (opnd_b),
      .sub (1'b0),
      .sum (tgt_sum)
   );

   assign jump_target = {tgt_sum[XLEN-1:1], 1'b0};
   assign link_addr   = pc_in + (short_insn ? XLEN'(SHORT_ILEN) : XLEN'(FULL_ILEN));

   // ---------------- result select ----------------
   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB, OP_PC_ADD: result = add_res;
         OP_SLL, OP_SRL, OP_SRA:    result = sh_res;
         OP_SLT:                    result = {{(XLEN-1){1'b0}}, cmp_lt};
         OP_SLTU:                   result = {{(XLEN-1){1'b0}}, cmp_ltu};
         OP_XOR:                    result = opnd_a ^ opnd_b;
         OP_OR:                     result = opnd_a | opnd_b;
         OP_AND:                    result = opnd_a & opnd_b;
         OP_PASS_B:                 result = opnd_b;
         default:                   result = '0;
      endcase
   end
endmodule

// File: rtl/rvx_int_exec_chk.sv
module rvx_int_exec_chk #(
   parameter int unsigned XLEN = 64,
   parameter int unsigned WLEN = 32
) (
   input logic [3:0]      op_sel,
   input logic            word_mode,
   input logic [XLEN-1:0] opnd_a,
   input logic [XLEN-1:0] opnd_b,
   input logic [XLEN-1:0] pc_in,
   input logic            short_insn,
   input logic [XLEN-1:0] result,
   input logic [XLEN-1:0] link_addr,
   input logic [XLEN-1:0] jump_target,
   input logic            cmp_eq,
   input logic            cmp_lt,
   input logic            cmp_ltu
);
   logic known;
   logic word_op;

   assign known   = !$isunknown({op_sel, word_mode, opnd_a, opnd_b, pc_in, short_insn});
   assign word_op = word_mode && (op_sel inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7});

   always_comb begin
      if (known) begin
         // R2 / R6: word-mode results are sign-extended copies of bit WLEN-1
         assert_word_sext_R2: assert (!word_op ||
            result[XLEN-1:WLEN-1] == {(XLEN-WLEN+1){result[WLEN-1]}});
         // R3: set-less-than yields only 0 or 1
         assert_slt_bool_R3: assert (!(op_sel == 4'd3 || op_sel == 4'd4) ||
            result[XLEN-1:1] == '0);
         // R3: signed set-less-than agrees with the branch flag
         assert_slt_flag_R3: assert (op_sel != 4'd3 || result[0] == cmp_lt);
         // R7: pass-through returns the second operand
         assert_pass_b_R7: assert (op_sel != 4'd10 || result == opnd_b);
         // R8: unused op codes give zero
         assert_unused_zero_R8: assert (op_sel < 4'd12 || result == '0);
         // R9: link address is past the current instruction
         assert_link_ahead_R9: assert (link_addr - pc_in == (short_insn ? XLEN'(2) : XLEN'(4)));
         // R10: jump target is halfword aligned
         assert_tgt_even_R10: assert (jump_target[0] == 1'b0);
         // R11: equality excludes both orderings
         assert_flags_excl_R11: assert (!cmp_eq || (!cmp_lt && !cmp_ltu));
         // R11: same sign makes signed and unsigned order agree
         assert_flags_agree_R11: assert ((opnd_a[XLEN-1] != opnd_b[XLEN-1]) || (cmp_lt == cmp_ltu));
      end
   end
endmodule

bind rvx_int_exec rvx_int_exec_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
   .op_sel      (op_sel),
   .word_mode   (word_mode),
   .opnd_a      (opnd_a),
   .opnd_b      (opnd_b),
   .pc_in       (pc_in),
   .short_insn  (short_insn),
   .result      (result),
   .link_addr   (link_addr),
   .jump_target (jump_target),
   .cmp_eq      (cmp_eq),
   .cmp_lt      (cmp_lt),
   .cmp_ltu     (cmp_ltu)
);

// File: tb/rvx_int_exec_bench.sv
module rvx_int_exec_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic [3:0]  op_sel;
   logic        word_mode;
   logic [63:0] opnd_a, opnd_b, pc_in;
   logic        short_insn;
   logic [63:0] result, link_addr, jump_target;
   logic        cmp_eq, cmp_lt, cmp_ltu;

   int n_vec  = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rvx_int_exec u_rvx_int_exec (
      .op_sel      (op_sel),
      .word_mode   (word_mode),
      .opnd_a      (opnd_a),
      .opnd_b      (opnd_b),
      .pc_in       (pc_in),
      .short_insn  (short_insn),
      .result      (result),
      .link_addr   (link_addr),
      .jump_target (jump_target),
      .cmp_eq      (cmp_eq),
      .cmp_lt      (cmp_lt),
      .cmp_ltu     (cmp_ltu)
   );

   logic [63:0] pats [16] = '{
      64'h0, 64'h1, 64'h2, 64'h1F, 64'h20, 64'h3F,
      64'h7FFF_FFFF, 64'h8000_0000, 64'hFFFF_FFFF, 64'h1_0000_0000,
      64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hFFFF_FFFF_8000_0000, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210
   };

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] model(input logic [3:0] op, input logic w,
                                         input logic [63:0] a, input logic [63:0] b,
                                         input logic [63:0] pc);
      logic [31:0] lo;
      case (op)
         4'd0: return w ? sx32(a[31:0] + b[31:0]) : a + b;
         4'd1: return w ? sx32(a[31:0] - b[31:0]) : a - b;
         4'd2: begin lo = a[31:0] << b[4:0]; return w ? sx32(lo) : a << b[5:0]; end
         4'd3: return {63'd0, $signed(a) < $signed(b)};
         4'd4: return {63'd0, a < b};
         4'd5: return a ^ b;
         4'd6: begin lo = a[31:0] >> b[4:0]; return w ? sx32(lo) : a >> b[5:0]; end
         4'd7: begin
            lo = 32'($signed(a[31:0]) >>> b[4:0]);
            return w ? sx32(lo) : 64'($signed(a) >>> b[5:0]);
         end
         4'd8: return a | b;
         4'd9: return a & b;
         4'd10: return b;
         4'd11: return pc + b;
         default: return 64'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op, input logic w);
      case (op)
         4'd0, 4'd1:       return w ? "R2" : "R1";
         4'd2, 4'd6, 4'd7: return w ? "R6" : "R5";
         4'd3, 4'd4:       return "R3";
         4'd5, 4'd8, 4'd9: return "R4";
         4'd10, 4'd11:     return "R7";
         default:          return "R8";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s op=%0d w=%0b a=%h b=%h act=%h exp=%h",
                  req, what, op_sel, word_mode, opnd_a, opnd_b, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic w, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] pc, input logic sh);
      logic [63:0] sum;
      op_sel = op; word_mode = w; opnd_a = a; opnd_b = b; pc_in = pc; short_insn = sh;
      #(CLK_PERIOD/2);
      n_vec++;
      sum = a + b;
      check(req_of(op, w), "result", result, model(op, w, a, b, pc));
      check("R9", "link", link_addr, pc + (sh ? 64'd2 : 64'd4));
      check("R10", "target", jump_target, {sum[63:1], 1'b0});
      check("R11", "eq", {63'd0, cmp_eq}, {63'd0, a == b});
      check("R11", "lt", {63'd0, cmp_lt}, {63'd0, $signed(a) < $signed(b)});
      check("R11", "ltu", {63'd0, cmp_ltu}, {63'd0, a < b});
      #(CLK_PERIOD/2);
   endtask

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      // idle state: all-zero inputs (R1)
      apply(4'd0, 1'b0, 64'd0, 64'd0, 64'd0, 1'b0);
      check("R1", "idle result", result, 64'd0);

      // full grid: every op code, both modes, corner operands
      for (int op = 0; op < 16; op++)
         for (int w = 0; w < 2; w++)
            for (int i = 0; i < 16; i++)
               for (int j = 0; j < 16; j++)
                  apply(4'(op), 1'(w), pats[i], pats[j],
                        pats[(i + j) % 16] ^ 64'h1000, 1'((i ^ j) & 1));

      // every shift amount with junk in the upper amount bits (R5, R6)
      for (int op = 0; op < 3; op++)
         for (int w = 0; w < 2; w++)
            for (int s = 0; s < 64; s++)
               for (int k = 10; k < 16; k++)
                  apply((op == 0) ? 4'd2 : (op == 1) ? 4'd6 : 4'd7, 1'(w),
                        pats[k], {58'h2AA_AAAA_AAAA_AAAA, 6'(s)}, 64'h8000, 1'(s & 1));

      // link address wraps at the top of the address space (R9)
      apply(4'd11, 1'b0, 64'd5, 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
      check("R9", "wrap", link_addr, 64'd2);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule